// File: doc/BRIEF.md
# Scoreboard Dynamic Scheduling Controller

This block is the hazard-tracking control for a pipeline in which instructions issue in program order but can finish out of order. Five multi-cycle functional units sit behind it: one integer/load unit, two multipliers, one adder that also handles subtraction, and one divider. Each clock it is offered at most one decoded instruction. The instruction carries an operation class, a destination register index and two source register indices. The block steps every accepted instruction through four phases: issue, operand read, execution and write-back.

Two tables hold the state. A per-unit status table records, for each unit, whether it is occupied, its destination and source registers, the unit expected to produce each source (unit tag 0 means no producer is pending), and a ready flag per source. A per-register table records which unit, if any, is due to write each register.

Each hazard is checked in a different phase. A write-after-write conflict, or an occupied unit of the needed class, holds the instruction at issue. A read-after-write dependence holds it before the operand read. A write-after-read conflict holds a finished result at write-back. Execution is modelled by a per-unit latency counter. No arithmetic is performed.

Top module: `sb_scoreboard`

## Requirements
- R1: After reset no unit is occupied. With no instruction offered, `issueStall`, `readOp`, `execStart` and `wbGrant` are all zero.
- R2: Unit identifiers are 1 = integer/load, 2 = first multiplier, 3 = second multiplier, 4 = adder, 5 = divider. `readOp`, `execStart` and `wbGrant` bit k belongs to unit k+1. Operation class codes are 0 = load, 1 = multiply, 2 = add/subtract, 3 = divide. An accepted instruction goes to the lowest-numbered free unit of its class, and that unit's identifier appears on `issueUnit` in the issue cycle. At most one instruction issues per cycle.
- R3: An offered instruction whose class has no free unit raises `issueStall` and is held. It issues in the cycle after a unit of that class writes back.
- R4: An offered instruction whose destination register is already owed a result by an occupied unit raises `issueStall`. It issues in the cycle after that unit writes back.
- R5: An issued instruction pulses `readOp` only when no occupied unit still owes either of its source registers. A dependent instruction reads in the cycle after its producer writes back. With no dependence, it reads in the cycle after issue.
- R6: `execStart` pulses in the cycle after `readOp`. Execution lasts 1 cycle for load, 2 for add/subtract, 10 for multiply and 40 for divide. The earliest write-back falls at issue cycle + latency + 2, so a load spans four cycles from issue to write-back.
- R7: A finished unit does not write back while another occupied unit that has not yet read its operands still needs the old value of that destination register. It writes in the cycle after that reader pulses `readOp`.
- R8: At most one `wbGrant` bit is set per cycle. Among eligible finished units the lowest identifier wins, and the others hold their results until granted.
- R9: Write-back frees the unit and clears the register's pending-writer entry. An instruction issued in the same cycle as the write-back of its source's producer treats that source as ready and reads in the next cycle.
- R10: While a `wbGrant` bit is set, `wbReg` shows that unit's destination register index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | A decoded instruction is offered this cycle |
| instOp | input | 2 | Operation class (0 load, 1 multiply, 2 add/sub, 3 divide) |
| instDst | input | 5 | Destination register index |
| instSrcA | input | 5 | First source register index |
| instSrcB | input | 5 | Second source register index |
| issueStall | output | 1 | Offered instruction cannot issue this cycle |
| issueUnit | output | 3 | Unit receiving the instruction this cycle, 0 when none |
| readOp | output | 5 | Per-unit operand read strobe |
| execStart | output | 5 | Per-unit first-execution-cycle strobe |
| wbGrant | output | 5 | Per-unit write-back grant, at most one set |
| wbReg | output | 5 | Destination register of the granted unit |

## Verification
The bench sweeps every operation class across low, middle and top register indices and checks read, start and write-back cycles against latency arithmetic. Targeted cases follow.
- Structural and write-after-write stalls: a design that gets these wrong issues a cycle early or blocks forever.
- A read-after-write chain: a design that gets this wrong reads stale operands ahead of the producer.
- A write-after-read case, where a load finished long before must wait for a slow reader: a wrong design overwrites the register too soon.
- A three-way write-back collision: a wrong design grants two units at once or drops a held result.
- A source issued exactly in its producer's write-back cycle: a design without same-cycle release deadlocks on a stale tag.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
package sb_pkg;
  localparam int NUM_FU  = 5;
  localparam int UNIT_W  = 3;
  localparam int NUM_REG = 32;
  localparam int REG_W   = $clog2(NUM_REG);
  localparam int CNT_W   = 6;

  typedef logic [UNIT_W-1:0] unitId_t;
  typedef logic [REG_W-1:0]  regIdx_t;

  typedef enum logic [1:0] {OP_LOAD = 2'd0, OP_MUL = 2'd1, OP_ADD = 2'd2, OP_DIV = 2'd3} opClass_t;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_EXEC, ST_DONE} fuState_t;

  typedef struct packed {
    logic    busy;
    regIdx_t fi;
    regIdx_t fj;
    regIdx_t fk;
    unitId_t qj;
    unitId_t qk;
    logic    rj;
    logic    rk;
  } fuEntry_t;

  typedef struct packed {
    logic              issue;
    unitId_t           issueUnit;
    logic [NUM_FU-1:0] readOp;
    logic [NUM_FU-1:0] wbGrant;
  } ctrlStrobe_t;

  // Class served by unit slot idx (unit id = idx + 1)
  function automatic opClass_t unitKind(input int idx);
    case (idx)
      0:       return OP_LOAD;
      1, 2:    return OP_MUL;
      3:       return OP_ADD;
      default: return OP_DIV;
    endcase
  endfunction
endpackage

// File: rtl/sb_ctrl.sv
`timescale 1ns/1ps
module sb_ctrl
  import sb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instValid,
  input  opClass_t    instOp,
  input  unitId_t     dstOwner,
  input  fuEntry_t    fuTab   [NUM_FU],
  input  fuState_t    fuState [NUM_FU],
  output ctrlStrobe_t strobe,
  output logic        issueStall
);
  logic              found;
  unitId_t           cand;
  logic              issueOk;
  logic [NUM_FU-1:0] warBlock;
  logic [NUM_FU-1:0] eligible;
  logic [NUM_FU-1:0] grant;
  logic [NUM_FU-1:0] readVec;

  // Issue: free unit of the class, destination not already owed (structural + WAW)
  always_comb begin
    found = 1'b0;
    cand  = '0;
    for (int i = 0; i < NUM_FU; i++) begin
      if (!found && unitKind(i) == instOp && !fuTab[i].busy) begin
        found = 1'b1;
        cand  = unitId_t'(i + 1);
      end
    end
    issueOk = instValid && found && (dstOwner == '0);
  end

  // Operand read: both sources ready (RAW)
  always_comb begin
    for (int i = 0; i < NUM_FU; i++)
      readVec[i] = (fuState[i] == ST_WAIT) && fuTab[i].rj && fuTab[i].rk;
  end

  // Write-back: no unread consumer of the old destination value (WAR)
  always_comb begin
    for (int i = 0; i < NUM_FU; i++) begin
      warBlock[i] = 1'b0;
      for (int j = 0; j < NUM_FU; j++) begin
        if (j != i && fuTab[j].busy &&
            ((fuTab[j].rj && fuTab[j].fj == fuTab[i].fi) ||
             (fuTab[j].rk && fuTab[j].fk == fuTab[i].fi)))
          warBlock[i] = 1'b1;
      end
      eligible[i] = (fuState[i] == ST_DONE) && !warBlock[i];
    end
  end

  // Fixed priority: lowest unit id writes first
  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int i = 0; i < NUM_FU; i++) begin
      if (eligible[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  always_comb begin
    strobe.issue     = issueOk;
    strobe.issueUnit = issueOk ? cand : '0;
    strobe.readOp    = readVec;
    strobe.wbGrant   = grant;
  end
  assign issueStall = instValid && !issueOk;

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rstN) $onehot0(strobe.wbGrant)); // R8
  AST_ISSUE_OWNER_FREE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issue |-> (dstOwner == '0)); // R4
endmodule

// File: rtl/sb_datapath.sv
`timescale 1ns/1ps
module sb_datapath
  import sb_pkg::*;
#(
  parameter int LAT_LOAD = 1,
  parameter int LAT_ADD  = 2,
  parameter int LAT_MUL  = 10,
  parameter int LAT_DIV  = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  regIdx_t           instDst,
  input  regIdx_t           instSrcA,
  input  regIdx_t           instSrcB,
  output fuEntry_t          fuTab   [NUM_FU],
  output fuState_t          fuState [NUM_FU],
  output unitId_t           dstOwner,
  output logic [NUM_FU-1:0] execStart,
  output regIdx_t           wbReg
);
  unitId_t regStat [NUM_REG];
  unitId_t wbUnit;
  regIdx_t wbRegC;
  unitId_t srcAOwner, srcBOwner, qjNew, qkNew;

  always_comb begin
    wbUnit = '0;
    wbRegC = '0;
    for (int i = 0; i < NUM_FU; i++) begin
      if (strobe.wbGrant[i]) begin
        wbUnit = unitId_t'(i + 1);
        wbRegC = fuTab[i].fi;
      end
    end
  end
  assign wbReg = wbRegC;

  assign dstOwner  = regStat[instDst];
  assign srcAOwner = regStat[instSrcA];
  assign srcBOwner = regStat[instSrcB];
  // A producer writing this very cycle no longer counts as pending
  assign qjNew = (srcAOwner == wbUnit) ? '0 : srcAOwner;
  assign qkNew = (srcBOwner == wbUnit) ? '0 : srcBOwner;

  // Register result status table
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REG; r++) regStat[r] <= '0;
    end else begin
      if (wbUnit != '0) regStat[wbRegC] <= '0;
      if (strobe.issue) regStat[instDst] <= strobe.issueUnit;
    end
  end

  AST_OWNER_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (wbUnit != '0) |=> (regStat[$past(wbRegC)] != $past(wbUnit))); // R9

  for (genvar i = 0; i < NUM_FU; i++) begin : gUnit
    localparam opClass_t KIND = unitKind(i);
    localparam int LAT = (KIND == OP_LOAD) ? LAT_LOAD :
                         (KIND == OP_MUL)  ? LAT_MUL  :
                         (KIND == OP_ADD)  ? LAT_ADD  : LAT_DIV;
    localparam unitId_t MY_ID = unitId_t'(i + 1);

    fuEntry_t          entQ;
    fuState_t          stQ;
    logic [CNT_W-1:0]  cntQ;
    logic              startQ;
    logic              issueHere;

    assign issueHere = strobe.issue && (strobe.issueUnit == MY_ID);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entQ   <= '0;
        stQ    <= ST_IDLE;
        cntQ   <= '0;
        startQ <= 1'b0;
      end else begin
        startQ <= strobe.readOp[i];
        if (issueHere) begin
          entQ.busy <= 1'b1;
          entQ.fi   <= instDst;
          entQ.fj   <= instSrcA;
          entQ.fk   <= instSrcB;
          entQ.qj   <= qjNew;
          entQ.qk   <= qkNew;
          entQ.rj   <= (qjNew == '0);
          entQ.rk   <= (qkNew == '0);
          stQ       <= ST_WAIT;
        end else begin
          if (strobe.readOp[i]) begin
            stQ     <= ST_EXEC;
            cntQ    <= CNT_W'(LAT - 1);
            entQ.rj <= 1'b0;
            entQ.rk <= 1'b0;
          end else if (stQ == ST_EXEC) begin
            if (cntQ == '0) stQ <= ST_DONE;
            else            cntQ <= cntQ - 1'b1;
          end else if (strobe.wbGrant[i]) begin
            entQ.busy <= 1'b0;
            stQ       <= ST_IDLE;
          end
          if (wbUnit != '0 && entQ.qj == wbUnit) begin
            entQ.qj <= '0;
            entQ.rj <= 1'b1;
          end
          if (wbUnit != '0 && entQ.qk == wbUnit) begin
            entQ.qk <= '0;
            entQ.rk <= 1'b1;
          end
        end
      end
    end

    assign fuTab[i]     = entQ;
    assign fuState[i]   = stQ;
    assign execStart[i] = startQ;

    AST_ISSUE_TO_FREE: assert property (@(posedge clk) disable iff (!rstN)
      issueHere |-> !entQ.busy); // R3
    AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
      strobe.readOp[i] |=> (stQ == ST_EXEC && !entQ.rj && !entQ.rk)); // R5
    AST_WB_WHEN_DONE: assert property (@(posedge clk) disable iff (!rstN)
      strobe.wbGrant[i] |-> (stQ == ST_DONE)); // R6
    AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rstN)
      (stQ == ST_DONE && !strobe.wbGrant[i]) |=> (stQ == ST_DONE)); // R8
    AST_WB_FREES: assert property (@(posedge clk) disable iff (!rstN)
      strobe.wbGrant[i] |=> !entQ.busy); // R9
  end
endmodule

// File: rtl/sb_scoreboard.sv
`timescale 1ns/1ps
module sb_scoreboard
  import sb_pkg::*;
#(
  parameter int LAT_LOAD = 1,
  parameter int LAT_ADD  = 2,
  parameter int LAT_MUL  = 10,
  parameter int LAT_DIV  = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [1:0]        instOp,
  input  logic [REG_W-1:0]  instDst,
  input  logic [REG_W-1:0]  instSrcA,
  input  logic [REG_W-1:0]  instSrcB,
  output logic              issueStall,
  output logic [UNIT_W-1:0] issueUnit,
  output logic [NUM_FU-1:0] readOp,
  output logic [NUM_FU-1:0] execStart,
  output logic [NUM_FU-1:0] wbGrant,
  output logic [REG_W-1:0]  wbReg
);
  ctrlStrobe_t strobe;
  fuEntry_t    fuTab   [NUM_FU];
  fuState_t    fuState [NUM_FU];
  unitId_t     dstOwner;

  sb_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .instValid  (instValid),
    .instOp     (opClass_t'(instOp)),
    .dstOwner   (dstOwner),
    .fuTab      (fuTab),
    .fuState    (fuState),
    .strobe     (strobe),
    .issueStall (issueStall)
  );

  sb_datapath #(
    .LAT_LOAD (LAT_LOAD),
    .LAT_ADD  (LAT_ADD),
    .LAT_MUL  (LAT_MUL),
    .LAT_DIV  (LAT_DIV)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .instDst   (instDst),
    .instSrcA  (instSrcA),
    .instSrcB  (instSrcB),
    .fuTab     (fuTab),
    .fuState   (fuState),
    .dstOwner  (dstOwner),
    .execStart (execStart),
    .wbReg     (wbReg)
  );

  assign issueUnit = strobe.issueUnit;
  assign readOp    = strobe.readOp;
  assign wbGrant   = strobe.wbGrant;
endmodule

// File: tb/sim_sb_scoreboard.sv
`timescale 1ns/1ps
module sim_sb_scoreboard;
  logic       clk = 1'b0;
  logic       rstN;
  logic       instValid;
  logic [1:0] instOp;
  logic [4:0] instDst, instSrcA, instSrcB;
  logic       issueStall;
  logic [2:0] issueUnit;
  logic [4:0] readOp, execStart, wbGrant, wbReg;

  always #10 clk = ~clk;

  sb_scoreboard u0 (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instOp(instOp),
    .instDst(instDst), .instSrcA(instSrcA), .instSrcB(instSrcB),
    .issueStall(issueStall), .issueUnit(issueUnit), .readOp(readOp),
    .execStart(execStart), .wbGrant(wbGrant), .wbReg(wbReg)
  );

  int cyc = 0;
  int lastRead [1:5];
  int lastStart[1:5];
  int lastWb   [1:5];
  int lastWbReg[1:5];
  int nChecks = 0;
  int nFail = 0;

  // Sample 5 ns before each rising edge
  always begin
    @(negedge clk);
    #5;
    cyc++;
    for (int u = 1; u <= 5; u++) begin
      if (readOp[u-1])    lastRead[u]  = cyc;
      if (execStart[u-1]) lastStart[u] = cyc;
      if (wbGrant[u-1]) begin
        lastWb[u]    = cyc;
        lastWbReg[u] = int'(wbReg);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearLog();
    for (int u = 1; u <= 5; u++) begin
      lastRead[u] = -1; lastStart[u] = -1; lastWb[u] = -1; lastWbReg[u] = -1;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doIssue(input int op, input int dst, input int a, input int b,
                         output int ic, output int unit, output int stalls);
    stalls = 0;
    @(negedge clk);
    instValid = 1'b1;
    instOp    = 2'(op);
    instDst   = 5'(dst);
    instSrcA  = 5'(a);
    instSrcB  = 5'(b);
    #6;
    while (issueStall) begin
      stalls++;
      @(negedge clk);
      #6;
    end
    ic   = cyc;
    unit = int'(issueUnit);
    @(posedge clk);
    #1 instValid = 1'b0;
  endtask

  function automatic int latOf(input int op);
    case (op)
      0: return 1;
      1: return 10;
      2: return 2;
      default: return 40;
    endcase
  endfunction

  function automatic int unitOf(input int op);
    case (op)
      0: return 1;
      1: return 2;
      2: return 4;
      default: return 5;
    endcase
  endfunction

  initial begin
    #3000000;
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    int c0, c1, c2, u, s, dst;
    rstN = 1'b0; instValid = 1'b0; instOp = '0; instDst = '0; instSrcA = '0; instSrcB = '0;
    clearLog();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #6;
    // R1 reset state
    check("R1 issueStall", int'(issueStall), 0);
    check("R1 readOp", int'(readOp), 0);
    check("R1 execStart", int'(execStart), 0);
    check("R1 wbGrant", int'(wbGrant), 0);

    // Sweep: every class, several register indices (R2 R5 R6 R10)
    for (int op = 0; op < 4; op++) begin
      for (int k = 0; k < 3; k++) begin
        dst = k * 15 + 1;
        clearLog();
        doIssue(op, dst, (dst + 3) % 32, (dst + 9) % 32, c0, u, s);
        idle(latOf(op) + 4);
        check("R2 unit", u, unitOf(op));
        check("R2 no stall", s, 0);
        check("R5 read after issue", lastRead[unitOf(op)], c0 + 1);
        check("R6 exec start", lastStart[unitOf(op)], c0 + 2);
        check("R6 writeback cycle", lastWb[unitOf(op)], c0 + latOf(op) + 2);
        check("R10 wbReg", lastWbReg[unitOf(op)], dst);
      end
    end

    // R3 structural: second add waits for the only adder
    idle(5);
    clearLog();
    doIssue(2, 20, 21, 22, c0, u, s);
    doIssue(2, 23, 24, 25, c1, u, s);
    check("R3 add stall count", s, 4);
    check("R3 add issue cycle", c1, c0 + 5);
    idle(8);

    // R2/R3 two multipliers, third waits
    clearLog();
    doIssue(1, 10, 11, 12, c0, u, s);
    check("R2 first mult unit", u, 2);
    doIssue(1, 13, 14, 15, c1, u, s);
    check("R2 second mult unit", u, 3);
    doIssue(1, 16, 17, 18, c2, u, s);
    check("R3 third mult issue", c2, c0 + 13);
    check("R3 third mult unit", u, 2);
    idle(20);

    // R4 WAW: mult to F2 waits for load to F2
    clearLog();
    doIssue(0, 2, 9, 9, c0, u, s);
    doIssue(1, 2, 7, 8, c1, u, s);
    check("R4 WAW stall count", s, 3);
    check("R4 WAW issue cycle", c1, c0 + 4);
    idle(20);

    // R5 RAW: add reads after load writes F2
    clearLog();
    doIssue(0, 2, 9, 9, c0, u, s);
    doIssue(2, 4, 2, 5, c1, u, s);
    idle(12);
    check("R5 RAW read cycle", lastRead[4], c0 + 4);
    check("R5 RAW writeback", lastWb[4], c0 + 7);

    // R9 issue in the producer's write-back cycle
    idle(5);
    clearLog();
    doIssue(0, 3, 9, 9, c0, u, s);
    idle(2);
    doIssue(2, 6, 3, 3, c1, u, s);
    idle(8);
    check("R9 same-cycle issue", c1, c0 + 3);
    check("R9 same-cycle read", lastRead[4], c0 + 4);
    check("R9 same-cycle writeback", lastWb[4], c0 + 7);

    // R7 WAR: load to F8 waits until add reads old F8
    idle(5);
    clearLog();
    doIssue(1, 2, 5, 5, c0, u, s);
    doIssue(2, 6, 2, 8, c1, u, s);
    doIssue(0, 8, 9, 9, c2, u, s);
    idle(20);
    check("R7 mult writeback", lastWb[2], c0 + 12);
    check("R7 add read", lastRead[4], c0 + 13);
    check("R7 load held by WAR", lastWb[1], c0 + 14);
    check("R7 add writeback", lastWb[4], c0 + 16);

    // R8 three-way write-back collision
    idle(5);
    clearLog();
    doIssue(1, 10, 11, 12, c0, u, s);
    doIssue(1, 13, 14, 15, c1, u, s);
    idle(7);
    doIssue(0, 16, 17, 17, c2, u, s);
    idle(10);
    check("R8 load issue cycle", c2, c0 + 9);
    check("R8 load wins", lastWb[1], c0 + 12);
    check("R8 mult1 second", lastWb[2], c0 + 13);
    check("R8 mult2 held", lastWb[3], c0 + 14);
    check("R10 held wbReg", lastWbReg[3], 13);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule